// File: doc/BRIEF.md
# Supply and Watchdog Reset Generator

This block drives a processor's reset line from three causes: power arriving, the supply dropping below its trip level, and a watchdog that the processor failed to service in time. An external comparator supplies a digital "supply above trip" level. A separate "power present" level clears all internal state asynchronously. The chip-select pin doubles as the watchdog service input, so every falling edge of chip select counts as a kick.

A free-running prescaler divides the system clock into ticks, and all intervals are counted in those ticks. After any reset the supply must stay above trip for a fixed settle count of ticks before reset is released. A two-bit selector picks one of three watchdog timeouts or switches the watchdog off. When the watchdog expires it raises a one-cycle pulse, so the status logic can record that this reset came from the watchdog and not from low supply. A build parameter sets the polarity of the reset output.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `pwr_present` is low, reset is active at once without waiting for a clock edge, and `wdt_flag_set` is low.
- R2: If `supply_ok` is low at a rising clock edge, reset is active after that edge, and the settle and watchdog counts restart.
- R3: Reset is released on the SETTLE_TICKS-th tick after `supply_ok` has been high without a break. The prescaler is held clear while the supply is low, so release comes exactly SETTLE_TICKS*CLK_DIV cycles after the first edge that sees the supply high. Any low sample restarts the whole wait.
- R4: `cs_wdi` passes through a two-flop synchronizer. Only a high-to-low transition restarts the watchdog count. If the pin stays low or stays high past the selected timeout, the watchdog fires.
- R5: `wd_sel` encoding: 2'b00 gives the WD_LONG timeout, 2'b01 gives WD_MID, 2'b10 gives WD_SHORT, and 2'b11 disables the watchdog.
- R6: When the watchdog fires, reset becomes active and `wdt_flag_set` is high for exactly that one cycle. A reset caused by low supply or by power loss never pulses the flag.
- R7: After a watchdog reset, reset is held for the same settle period. The watchdog then counts again from zero, so with no kicks it fires again one full timeout after the release.
- R8: With ACTIVE_HIGH=0 the output is low while in reset. With ACTIVE_HIGH=1 it is high while in reset.
- R9: While reset is active, kicks on `cs_wdi` have no effect and the watchdog cannot fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_present | input | 1 | Supply present; low clears all state asynchronously |
| supply_ok | input | 1 | Comparator output, high while the supply is above trip |
| cs_wdi | input | 1 | Chip select and watchdog service input |
| wd_sel | input | 2 | Watchdog interval selector |
| rst_out | output | 1 | Processor reset, polarity set by ACTIVE_HIGH |
| wdt_flag_set | output | 1 | One-cycle pulse when the watchdog causes a reset |

## Verification
A supply drop shows on the reset pin one cycle after it is driven. A release comes exactly SETTLE_TICKS*CLK_DIV cycles after the rise, because the prescaler restarts with the supply. A watchdog expiry lands two synchronizer cycles plus between L-1 and L ticks after the kick, since the prescaler phase at the kick is free. The driver pushes each expected event into a queue as a cycle window, either absolute from the stimulus or relative to the previous event. The monitor stamps each change of reset and each flag pulse at the falling clock edge and pops the queue, so any event that arrives unannounced is a failure. Timeout windows are kept narrow enough that the three intervals, and a kick that was wrongly taken on the rising edge, land outside each other's windows.

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int CLK_DIV      = 50000,
  parameter int SETTLE_TICKS = 200,
  parameter int WD_LONG      = 1400,
  parameter int WD_MID       = 600,
  parameter int WD_SHORT     = 200,
  parameter bit ACTIVE_HIGH  = 1'b0
) (
  input  logic       clk,
  input  logic       pwr_present,
  input  logic       supply_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       rst_out,
  output logic       wdt_flag_set
);
  localparam int PRE_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int SET_W  = $clog2(SETTLE_TICKS + 1);
  localparam int WD_MAX = (WD_LONG > WD_MID) ? ((WD_LONG > WD_SHORT) ? WD_LONG : WD_SHORT)
                                             : ((WD_MID > WD_SHORT) ? WD_MID : WD_SHORT);
  localparam int WD_W   = $clog2(WD_MAX + 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [SET_W-1:0] settle_cnt;
  logic [WD_W-1:0]  wd_cnt, wd_lim;
  logic [1:0]       cs_q;
  logic             rst_act, tick, kick, wd_on;

  assign tick  = (pre_cnt == PRE_W'(CLK_DIV - 1));
  assign kick  = cs_q[1] & ~cs_q[0];
  assign wd_on = (wd_sel != 2'b11);

  always_comb begin
    case (wd_sel)
      2'b00:   wd_lim = WD_W'(WD_LONG);
      2'b01:   wd_lim = WD_W'(WD_MID);
      2'b10:   wd_lim = WD_W'(WD_SHORT);
      default: wd_lim = '0;
    endcase
  end

  always_ff @(posedge clk or negedge pwr_present) begin
    if (!pwr_present) begin
      pre_cnt <= '0;
      cs_q    <= 2'b11;
    end else begin
      cs_q <= {cs_q[0], cs_wdi};
      if (!supply_ok || tick) pre_cnt <= '0;
      else                    pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwr_present) begin
    if (!pwr_present) begin
      rst_act      <= 1'b1;
      settle_cnt   <= '0;
      wd_cnt       <= '0;
      wdt_flag_set <= 1'b0;
    end else begin
      wdt_flag_set <= 1'b0;
      if (!supply_ok) begin
        rst_act    <= 1'b1;
        settle_cnt <= '0;
        wd_cnt     <= '0;
      end else if (rst_act) begin
        wd_cnt <= '0;
        if (tick) begin
          if (settle_cnt == SET_W'(SETTLE_TICKS - 1)) begin
            rst_act    <= 1'b0;
            settle_cnt <= '0;
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
      end else if (!wd_on || kick) begin
        wd_cnt <= '0;
      end else if (tick) begin
        if (wd_cnt >= wd_lim - 1'b1) begin
          rst_act      <= 1'b1;
          wdt_flag_set <= 1'b1;
          wd_cnt       <= '0;
        end else begin
          wd_cnt <= wd_cnt + 1'b1;
        end
      end
    end
  end

  assign rst_out = ACTIVE_HIGH ? rst_act : ~rst_act;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk #(
  parameter int SETTLE_TICKS = 200,
  parameter int SET_W        = 8,
  parameter int WD_MAX       = 1400,
  parameter int WD_W         = 11
) (
  input logic             clk,
  input logic             pwr_present,
  input logic             supply_ok,
  input logic             rst_act,
  input logic             flag,
  input logic [SET_W-1:0] settle_cnt,
  input logic [WD_W-1:0]  wd_cnt
);
  AST_LOWV_RESET: assert property (@(posedge clk) disable iff (!pwr_present)
    !supply_ok |=> rst_act); // R2
  AST_RELEASE_SUPPLY_GOOD: assert property (@(posedge clk) disable iff (!pwr_present)
    $fell(rst_act) |-> $past(supply_ok)); // R3
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!pwr_present)
    settle_cnt < SET_W'(SETTLE_TICKS)); // R3
  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!pwr_present)
    wd_cnt < WD_W'(WD_MAX)); // R4
  AST_FLAG_WITH_RESET: assert property (@(posedge clk) disable iff (!pwr_present)
    flag |-> rst_act); // R6
  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (!pwr_present)
    flag |=> !flag); // R6
  AST_FLAG_NOT_LOWV: assert property (@(posedge clk) disable iff (!pwr_present)
    flag |-> $past(supply_ok)); // R6
  AST_WD_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!pwr_present)
    $past(rst_act) && rst_act |-> wd_cnt == '0); // R9
endmodule

bind sup_reset_wdog sup_reset_wdog_chk #(
  .SETTLE_TICKS(SETTLE_TICKS), .SET_W(SET_W), .WD_MAX(WD_MAX), .WD_W(WD_W)
) chk_i (
  .clk(clk), .pwr_present(pwr_present), .supply_ok(supply_ok), .rst_act(rst_act),
  .flag(wdt_flag_set), .settle_cnt(settle_cnt), .wd_cnt(wd_cnt)
);

// File: tb/sup_reset_wdog_tb_top.sv
module sup_reset_wdog_tb_top;
  localparam int DIV = 4, SET = 10, WL = 30, WM = 16, WS = 8;
  localparam int EV_ASSERT = 0, EV_RELEASE = 1, EV_FLAG = 2;

  typedef struct {
    int kind; bit rel; int base; int lo; int hi; int req;
  } exp_t;

  logic clk = 1'b0, pwr_present = 1'b0, supply_ok = 1'b0, cs_wdi = 1'b1;
  logic [1:0] wd_sel = 2'b11;
  logic rst_out, rst_hi, wdt_flag_set, flag_hi;
  int cyc = 0, n_tests = 0, n_fail = 0, last_ev = 0, kbase = 0;
  bit mon_on = 1'b0, prev_rst = 1'b0, done = 1'b0;
  exp_t exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sup_reset_wdog #(.CLK_DIV(DIV), .SETTLE_TICKS(SET), .WD_LONG(WL), .WD_MID(WM),
    .WD_SHORT(WS), .ACTIVE_HIGH(1'b0)) dut_i (
    .clk(clk), .pwr_present(pwr_present), .supply_ok(supply_ok), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .rst_out(rst_out), .wdt_flag_set(wdt_flag_set));

  sup_reset_wdog #(.CLK_DIV(DIV), .SETTLE_TICKS(SET), .WD_LONG(WL), .WD_MID(WM),
    .WD_SHORT(WS), .ACTIVE_HIGH(1'b1)) dut_hi (
    .clk(clk), .pwr_present(pwr_present), .supply_ok(supply_ok), .cs_wdi(cs_wdi),
    .wd_sel(wd_sel), .rst_out(rst_hi), .wdt_flag_set(flag_hi));

  task automatic check(input bit ok, input int req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic push(input int kind, input bit rel, input int base, input int lo,
                      input int hi, input int req);
    exp_t e;
    e.kind = kind; e.rel = rel; e.base = base; e.lo = lo; e.hi = hi; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic event_seen(input int kind);
    exp_t e;
    int ref_c;
    if (exp_q.size() == 0) begin
      check(1'b0, 0, kind, -1);
    end else begin
      e = exp_q.pop_front();
      ref_c = e.rel ? last_ev : e.base;
      check(e.kind == kind, e.req, kind, e.kind);
      check(cyc >= ref_c + e.lo && cyc <= ref_c + e.hi, e.req, cyc - ref_c, e.lo);
    end
    last_ev = cyc;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (rst_out != prev_rst) event_seen(rst_out ? EV_RELEASE : EV_ASSERT);
      if (wdt_flag_set) event_seen(EV_FLAG);
      prev_rst = rst_out;
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic kick;
    cs_wdi = 1'b1;
    wait_n(3);
    kbase = cyc;
    cs_wdi = 1'b0;
  endtask

  task automatic expect_wd(input int lim, input int req);
    push(EV_ASSERT, 1'b0, kbase, (lim - 1) * DIV, lim * DIV + 4, req);
    push(EV_FLAG, 1'b1, 0, 0, 0, 6);                 // R6 flag in same cycle
    push(EV_RELEASE, 1'b1, 0, (SET - 1) * DIV, SET * DIV + 1, 7); // R7 settle
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait (cyc > 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected end before 100000", cyc);
    finish_up();
  end

  initial begin
    wait_n(4);
    check(rst_out == 1'b0, 1, rst_out, 0);          // R1
    check(rst_hi == 1'b1, 8, rst_hi, 1);            // R8
    check(wdt_flag_set == 1'b0, 1, wdt_flag_set, 0); // R1
    prev_rst = rst_out;
    mon_on = 1'b1;

    pwr_present = 1'b1;
    wait_n(20);
    check(rst_out == 1'b0, 2, rst_out, 0);          // R2 supply still low

    push(EV_RELEASE, 1'b0, cyc, SET * DIV - 2, SET * DIV + 2, 3); // R3
    supply_ok = 1'b1;
    drain();
    check(rst_out == 1'b1 && rst_hi == 1'b0, 8, {rst_out, rst_hi}, 2); // R8

    wait_n(200);                                    // R5 code 11 disabled
    check(rst_out == 1'b1, 5, rst_out, 1);

    wd_sel = 2'b10;
    kick();
    expect_wd(WS, 4);                               // R4 short interval
    drain();

    push(EV_ASSERT, 1'b1, 0, (WS - 1) * DIV - 1, WS * DIV + 2, 7); // R7 restart from zero
    push(EV_FLAG, 1'b1, 0, 0, 0, 6);
    push(EV_RELEASE, 1'b1, 0, (SET - 1) * DIV, SET * DIV + 1, 7);
    drain();

    for (int k = 0; k < 10; k++) begin              // R4 kicks keep reset away
      kick();
      wait_n(17);
    end
    check(rst_out == 1'b1, 4, rst_out, 1);
    expect_wd(WS, 4);                               // R4 pin held low
    drain();

    kick();
    wait_n(20);
    cs_wdi = 1'b1;                                  // R4 rising edge is no kick
    expect_wd(WS, 4);
    drain();

    wd_sel = 2'b01;
    kick();
    expect_wd(WM, 5);                               // R5 code 01
    drain();

    wd_sel = 2'b00;
    kick();
    expect_wd(WL, 5);                               // R5 code 00
    drain();
    wd_sel = 2'b11;

    push(EV_ASSERT, 1'b0, cyc, 1, 2, 2);            // R2 brownout
    supply_ok = 1'b0;
    drain();
    for (int k = 0; k < 5; k++) begin               // R9 kicks ignored in reset
      kick();
      wait_n(3);
    end
    wait_n(15);
    check(rst_out == 1'b0, 9, rst_out, 0);          // R9

    supply_ok = 1'b1;
    wait_n(20);
    supply_ok = 1'b0;                               // R3 break restarts settle
    wait_n(5);
    push(EV_RELEASE, 1'b0, cyc, SET * DIV - 2, SET * DIV + 2, 3); // R3
    supply_ok = 1'b1;
    drain();

    wd_sel = 2'b10;
    kick();
    wait_n(10);
    push(EV_ASSERT, 1'b0, cyc, 1, 2, 6);            // R6 no flag on low supply
    supply_ok = 1'b0;
    wait_n(60);
    push(EV_RELEASE, 1'b0, cyc, SET * DIV - 2, SET * DIV + 2, 3);
    supply_ok = 1'b1;
    drain();
    wd_sel = 2'b11;
    wait_n(50);

    push(EV_ASSERT, 1'b0, cyc, 0, 2, 1);            // R1 power loss
    pwr_present = 1'b0;
    drain();
    wait_n(3);
    check(rst_hi == 1'b1 && wdt_flag_set == 1'b0, 1, {rst_hi, wdt_flag_set}, 2); // R1
    check(exp_q.size() == 0, 0, exp_q.size(), 0);
    finish_up();
  end
endmodule